// File: doc/BRIEF.md
# Set/Clear Register GPIO Bank

This block is one memory-mapped port of 32 general-purpose pins. Software reaches it through a simple register port that carries a valid strobe, a write flag, a byte address and 32 bits of data. Each register holds one bit per pin, and registers sit on a 4-byte stride.

Pin direction and output data never need a read-modify-write. Each has a dedicated "write ones to set" address and a dedicated "write ones to clear" address, and bits written as zero are left alone. The block drives the output latch and the output enables to the pads.

Pad inputs pass through a two-flop synchroniser. The synchronised value is what software reads as the pin level, and it is also brought out for a separate interrupt block. Reading the data-set address returns the output latch rather than the pin level, so software can confirm the value it is driving.

Top module: `pinbank_sc`

## Requirements
- R1: After reset every pin is an input and the output latch is zero. So `pad_oe` is 0, `pad_out` is 0, a read of offset 0x00 returns 0xFFFFFFFF and a read of offset 0x10 returns 0.
- R2: A write to offset 0x04 turns every pin whose data bit is 1 into an output (its `pad_oe` bit becomes 1). Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x08 turns every pin whose data bit is 1 into an input (its `pad_oe` bit becomes 0). Pins whose data bit is 0 keep their direction.
- R4: A write to offset 0x10 sets the output latch bits whose data bit is 1, and a write to offset 0x14 clears them. Zero bits are unchanged, and `pad_out` always equals the latch.
- R5: A read of offset 0x00 returns the direction state, with bit n set to 1 when pin n is an input and 0 when it is an output. This is the bitwise inverse of `pad_oe`.
- R6: A read of offset 0x10 returns the output latch contents, whatever level is present on `pad_in`.
- R7: A change on `pad_in` appears on `pin_sync` after exactly two rising clock edges. A read of offset 0x0C returns `pin_sync`.
- R8: Writes to the read-only offsets 0x00 and 0x0C change neither the direction state nor the output latch.
- R9: A read of any offset other than 0x00, 0x0C and 0x10 returns zero. This includes the write-only offsets 0x04, 0x08 and 0x14 and all unmapped offsets. The two low address bits are ignored.
- R10: A read accepted on one rising edge puts its data on `reg_rdata` and raises `reg_rvalid` for exactly the following cycle. `reg_rvalid` stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data, one bit per pin |
| reg_rdata | output | 32 | Read data, valid while reg_rvalid is high |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output latch driven to the pads |
| pad_oe | output | 32 | Pad output enable, 1 = driving |
| pin_sync | output | 32 | Synchronised pin levels for interrupt logic |

## Verification
A wrong bit in the direction state shows on `pad_oe` on the cycle after the write that caused it. A wrong bit in the output latch shows on `pad_out` in the same way. Both wrong states also show in the readback of offsets 0x00 and 0x10 one cycle after the read is issued. A synchroniser with a missing or extra stage moves the `pin_sync` update by one edge, and that is caught by checking the value after the first edge and again after the second. A decode fault shows up as a nonzero read of a write-only offset, or as an unexpected change on the pads after a write to a read-only offset.

// File: rtl/pinbank_sc.sv
module pinbank_sc #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]   reg_wdata,
  output logic [PINS-1:0]   reg_rdata,
  output logic              reg_rvalid,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pin_sync
);
  localparam int WA = ADDR_W - 2;
  localparam logic [WA-1:0] W_DIR    = WA'(0);
  localparam logic [WA-1:0] W_MKOUT  = WA'(1);
  localparam logic [WA-1:0] W_MKIN   = WA'(2);
  localparam logic [WA-1:0] W_LEVEL  = WA'(3);
  localparam logic [WA-1:0] W_DSET   = WA'(4);
  localparam logic [WA-1:0] W_DCLR   = WA'(5);

  logic [WA-1:0]   widx;
  logic [PINS-1:0] is_in, latch, meta, sync;
  logic            wr, rd;

  assign widx     = reg_addr[ADDR_W-1:2];
  assign wr       = reg_valid && reg_write;
  assign rd       = reg_valid && !reg_write;
  assign pad_oe   = ~is_in;
  assign pad_out  = latch;
  assign pin_sync = sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_in <= '1;
      latch <= '0;
    end else if (wr) begin
      case (widx)
        W_MKOUT: is_in <= is_in & ~reg_wdata;
        W_MKIN:  is_in <= is_in | reg_wdata;
        W_DSET:  latch <= latch | reg_wdata;
        W_DCLR:  latch <= latch & ~reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= pad_in;
      sync <= meta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd;
      if (rd) begin
        case (widx)
          W_DIR:   reg_rdata <= is_in;
          W_LEVEL: reg_rdata <= sync;
          W_DSET:  reg_rdata <= latch;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r2_make_output: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == W_MKOUT) |=> ((pad_oe & $past(reg_wdata)) == $past(reg_wdata)));
  a_r3_make_input: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == W_MKIN) |=> ((pad_oe & $past(reg_wdata)) == '0));
  a_r4_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == W_DSET) |=> ((pad_out & $past(reg_wdata)) == $past(reg_wdata)));
  a_r4_latch_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == W_DCLR) |=> ((pad_out & $past(reg_wdata)) == '0));
  a_r8_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (widx == W_DIR || widx == W_LEVEL)) |=> ($stable(pad_oe) && $stable(pad_out)));
  a_r7_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (pin_sync == $past(pad_in, 2)));
  a_r10_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> reg_rvalid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !reg_rvalid);
  a_r5_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && widx == W_DIR) |=> (reg_rdata == ~$past(pad_oe)));
endmodule

// File: tb/pinbank_sc_bench.sv
module pinbank_sc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pin_sync;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pinbank_sc u_pinbank_sc (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pin_sync(pin_sync)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check("R1 pad_oe after reset", pad_oe, 32'h0);
    check("R1 pad_out after reset", pad_out, 32'h0);
    check("R10 rvalid idle", {31'd0, reg_rvalid}, 32'd0);
    rd(8'h00, 32'hFFFF_FFFF, "R1 R5 dir read after reset");
    rd(8'h10, 32'h0, "R1 R6 latch read after reset");

    wr(8'h04, 32'h0000_00F0);
    check("R2 make outputs", pad_oe, 32'h0000_00F0);
    check("R10 rvalid after write", {31'd0, reg_rvalid}, 32'd0);
    rd(8'h00, 32'hFFFF_FF0F, "R5 dir readback");
    wr(8'h04, 32'h0000_0F00);
    check("R2 zero bits unchanged", pad_oe, 32'h0000_0FF0);
    wr(8'h08, 32'h0000_0030);
    check("R3 make inputs", pad_oe, 32'h0000_0FC0);

    wr(8'h10, 32'hA5A5_0000);
    check("R4 latch set", pad_out, 32'hA5A5_0000);
    wr(8'h10, 32'h0000_0001);
    check("R4 set keeps others", pad_out, 32'hA5A5_0001);
    wr(8'h14, 32'h0500_0001);
    check("R4 latch clear", pad_out, 32'hA0A5_0000);

    pad_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(8'h10, 32'hA0A5_0000, "R6 latch not pin level");
    rd(8'h0C, 32'h1234_5678, "R7 level read");

    wr(8'h00, 32'h0000_0000);
    check("R8 dir write ignored", pad_oe, 32'h0000_0FC0);
    wr(8'h0C, 32'hFFFF_FFFF);
    check("R8 level write ignored oe", pad_oe, 32'h0000_0FC0);
    check("R8 level write ignored out", pad_out, 32'hA0A5_0000);
    rd(8'h00, 32'hFFFF_F03F, "R8 R5 dir after ro writes");

    rd(8'h04, 32'h0, "R9 write-only 0x04");
    rd(8'h08, 32'h0, "R9 write-only 0x08");
    rd(8'h14, 32'h0, "R9 write-only 0x14");
    rd(8'h18, 32'h0, "R9 unmapped 0x18");
    rd(8'hFC, 32'h0, "R9 unmapped 0xFC");
    rd(8'h13, 32'hA0A5_0000, "R9 low bits ignored");

    pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R7 one edge not yet", pin_sync, 32'h1234_5678);
    @(negedge clk);
    check("R7 two edges", pin_sync, 32'hDEAD_BEEF);
    rd(8'h0C, 32'hDEAD_BEEF, "R7 level read new");

    repeat (3) @(negedge clk);
    check("R10 all reads answered", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule